// File: doc/BRIEF.md
# Adaptive State Identifier for a Three-State Mealy Device

This block finds the unknown present state of an attached three-state Mealy device. It needs no reset or status input on the device. It probes the device with input symbols and picks each probe from the replies seen so far. The first probe is always symbol `a`. A reply of 1 settles the answer at once. A reply of 0 makes the block send symbol `b`, and the reply to that tells the two remaining states apart. The probe is therefore one or two symbols long, depending on where the device started.

When the probe ends, the block reports three things: the state the device was in before the probe, the state the probe left it in, and how many symbols were spent. A surrounding test sequencer uses the block to learn where a device sits before it runs further stimulus. The device answers each symbol through a reply/valid pair. If no reply arrives within a parameterised number of cycles, the block stops and flags a timeout.

Top module: `adsi_identifier`

## Requirements
- R1: After reset, busy_o, probe_valid_o, done_o and timeout_o are 0, and start_state_o, end_state_o and probe_len_o are 0.
- R2: A start_i sampled while busy_o is 0 causes, in the next cycle, a single-cycle probe_valid_o with probe_sym_o = 0 (symbol `a`). Symbol encoding: 0 = `a`, 1 = `b`.
- R3: If the reply to `a` is 1, the block issues no further symbol and reports start state 2, end state 2 and probe length 1. States are encoded as the numbers 1, 2 and 3.
- R4: If the reply to `a` is 0, the block issues probe_sym_o = 1 (symbol `b`) with probe_valid_o in the cycle after that reply is sampled.
- R5: After `b`, a reply of 1 reports start state 1 and end state 2, and a reply of 0 reports start state 3 and end state 1. In both cases the probe length is 2.
- R6: done_o is a one-cycle pulse in the cycle after the final reply is sampled. The result fields change only at that pulse and hold their values until the next completion.
- R7: If no reply is sampled within TIMEOUT_CYC cycles of waiting, done_o and timeout_o rise together and all three result fields read 0. A reply in the TIMEOUT_CYC-th waiting cycle is still accepted. timeout_o clears at the next successful completion.
- R8: start_i while busy_o is 1 has no effect, and resp_valid_i outside a waiting cycle is ignored.
- R9: busy_o is 1 from the cycle after an accepted start until the cycle that carries done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to begin an identification |
| busy_o | output | 1 | Identification in progress |
| probe_sym_o | output | 1 | Symbol sent to the device (0 = a, 1 = b) |
| probe_valid_o | output | 1 | probe_sym_o is valid this cycle |
| resp_bit_i | input | 1 | Device output bit |
| resp_valid_i | input | 1 | resp_bit_i is valid this cycle |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | Last run ended without a reply |
| start_state_o | output | 2 | Identified starting state (1..3, 0 on timeout) |
| end_state_o | output | 2 | State the device was left in (1..3, 0 on timeout) |
| probe_len_o | output | 2 | Symbols spent (1 or 2, 0 on timeout) |

## Verification
A wrong phase in the controller reaches the device port at once. A misrouted branch sends `b` where none should follow, or omits it where it should, one cycle after the first reply. The bench catches this by logging every symbol the device receives. A bad result decode reaches the ports with the done pulse, so each run compares the three fields with a behavioural model of the device. Timer faults show as a completion shifted by cycles, and the bench catches them by checking completion latency exactly, both at the last accepted reply cycle and one cycle past it.

// File: rtl/adsi_pkg.sv
package adsi_pkg;
  localparam int STATE_W = 2;
  localparam int LEN_W   = 2;

  localparam logic SYM_A = 1'b0;
  localparam logic SYM_B = 1'b1;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SEND_A,
    PH_WAIT_A,
    PH_SEND_B,
    PH_WAIT_B
  } phase_t;

  typedef struct packed {
    logic [STATE_W-1:0] first;
    logic [STATE_W-1:0] last;
    logic [LEN_W-1:0]   len;
  } verdict_t;

  // Reply of 1 to the opening symbol settles the state on its own.
  function automatic verdict_t verdict_after_a();
    verdict_t v;
    v.first = STATE_W'(2);
    v.last  = STATE_W'(2);
    v.len   = LEN_W'(1);
    return v;
  endfunction

  // The reply to the second symbol separates the two remaining states.
  function automatic verdict_t verdict_after_b(input logic reply);
    verdict_t v;
    v.first = reply ? STATE_W'(1) : STATE_W'(3);
    v.last  = reply ? STATE_W'(2) : STATE_W'(1);
    v.len   = LEN_W'(2);
    return v;
  endfunction
endpackage

// File: rtl/adsi_timer.sv
module adsi_timer #(
  parameter int TIMEOUT_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic waiting_i,
  input  logic reply_i,
  output logic expire_o
);
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!waiting_i)     cnt_q <= '0;
    else if (cnt_q != LAST)  cnt_q <= cnt_q + CNT_W'(1);
  end

  assign expire_o = waiting_i && !reply_i && (cnt_q == LAST);
endmodule

// File: rtl/adsi_ctrl.sv
module adsi_ctrl
  import adsi_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               resp_bit_i,
  input  logic               resp_valid_i,
  input  logic               expire_i,
  output logic               waiting_o,
  output logic               accept_o,
  output logic               busy_o,
  output logic               probe_sym_o,
  output logic               probe_valid_o,
  output logic               done_o,
  output logic               timeout_o,
  output verdict_t           verdict_o
);
  phase_t   phase_q;
  logic     done_q;
  logic     tmo_q;
  verdict_t res_q;

  assign waiting_o = (phase_q == PH_WAIT_A) || (phase_q == PH_WAIT_B);
  assign accept_o  = waiting_o && resp_valid_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      done_q  <= 1'b0;
      tmo_q   <= 1'b0;
      res_q   <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE:   if (start_i) phase_q <= PH_SEND_A;
        PH_SEND_A: phase_q <= PH_WAIT_A;
        PH_WAIT_A: begin
          if (expire_i) begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b1;
            tmo_q   <= 1'b1;
            res_q   <= '0;
          end else if (accept_o) begin
            if (resp_bit_i) begin
              phase_q <= PH_IDLE;
              done_q  <= 1'b1;
              tmo_q   <= 1'b0;
              res_q   <= verdict_after_a();
            end else begin
              phase_q <= PH_SEND_B;
            end
          end
        end
        PH_SEND_B: phase_q <= PH_WAIT_B;
        PH_WAIT_B: begin
          if (expire_i) begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b1;
            tmo_q   <= 1'b1;
            res_q   <= '0;
          end else if (accept_o) begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b1;
            tmo_q   <= 1'b0;
            res_q   <= verdict_after_b(resp_bit_i);
          end
        end
        default:   phase_q <= PH_IDLE;
      endcase
    end
  end

  assign busy_o        = (phase_q != PH_IDLE);
  assign probe_valid_o = (phase_q == PH_SEND_A) || (phase_q == PH_SEND_B);
  assign probe_sym_o   = (phase_q == PH_SEND_B) ? SYM_B : SYM_A;
  assign done_o        = done_q;
  assign timeout_o     = tmo_q;
  assign verdict_o     = res_q;
endmodule

// File: rtl/adsi_identifier.sv
module adsi_identifier
  import adsi_pkg::*;
#(
  parameter int TIMEOUT_CYC = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  output logic               busy_o,
  output logic               probe_sym_o,
  output logic               probe_valid_o,
  input  logic               resp_bit_i,
  input  logic               resp_valid_i,
  output logic               done_o,
  output logic               timeout_o,
  output logic [STATE_W-1:0] start_state_o,
  output logic [STATE_W-1:0] end_state_o,
  output logic [LEN_W-1:0]   probe_len_o
);
  logic     waiting_w;
  logic     accept_w;
  logic     expire_w;
  verdict_t verdict_w;

  adsi_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) timer_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .waiting_i (waiting_w),
    .reply_i   (resp_valid_i),
    .expire_o  (expire_w)
  );

  adsi_ctrl ctrl_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .resp_bit_i    (resp_bit_i),
    .resp_valid_i  (resp_valid_i),
    .expire_i      (expire_w),
    .waiting_o     (waiting_w),
    .accept_o      (accept_w),
    .busy_o        (busy_o),
    .probe_sym_o   (probe_sym_o),
    .probe_valid_o (probe_valid_o),
    .done_o        (done_o),
    .timeout_o     (timeout_o),
    .verdict_o     (verdict_w)
  );

  assign start_state_o = verdict_w.first;
  assign end_state_o   = verdict_w.last;
  assign probe_len_o   = verdict_w.len;
endmodule

// File: rtl/adsi_identifier_chk.sv
module adsi_identifier_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       busy_o,
  input logic       probe_sym_o,
  input logic       probe_valid_o,
  input logic       resp_bit_i,
  input logic       resp_valid_i,
  input logic       done_o,
  input logic       timeout_o,
  input logic [1:0] start_state_o,
  input logic [1:0] end_state_o,
  input logic [1:0] probe_len_o,
  input logic       waiting_w,
  input logic       expire_w
);
  a_r2_opens_with_a: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (probe_valid_o && probe_sym_o == 1'b0));

  a_r2_single_cycle_probe: assert property (@(posedge clk) disable iff (!rst_n)
    probe_valid_o |=> !probe_valid_o);

  a_r3_short_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !timeout_o && start_state_o == 2'd2) |-> (probe_len_o == 2'd1 && end_state_o == 2'd2));

  a_r4_b_after_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_valid_o && probe_sym_o) |-> ($past(resp_valid_i) && !$past(resp_bit_i)));

  a_r5_long_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !timeout_o && start_state_o != 2'd2) |-> (probe_len_o == 2'd2));

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r6_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(start_state_o) && $stable(end_state_o) && $stable(probe_len_o)));

  a_r7_expire_flags: assert property (@(posedge clk) disable iff (!rst_n)
    expire_w |=> (done_o && timeout_o && probe_len_o == 2'd0));

  a_r8_stray_reply: assert property (@(posedge clk) disable iff (!rst_n)
    (!waiting_w) |=> !done_o);

  a_r9_busy_cover: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_valid_o || waiting_w) |-> busy_o);
endmodule

bind adsi_identifier adsi_identifier_chk chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_i       (start_i),
  .busy_o        (busy_o),
  .probe_sym_o   (probe_sym_o),
  .probe_valid_o (probe_valid_o),
  .resp_bit_i    (resp_bit_i),
  .resp_valid_i  (resp_valid_i),
  .done_o        (done_o),
  .timeout_o     (timeout_o),
  .start_state_o (start_state_o),
  .end_state_o   (end_state_o),
  .probe_len_o   (probe_len_o),
  .waiting_w     (waiting_w),
  .expire_w      (expire_w)
);

// File: tb/adsi_identifier_tb_top.sv
module adsi_identifier_tb_top;
  localparam int TMO = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       busy_o, probe_sym_o, probe_valid_o, done_o, timeout_o;
  logic       resp_bit_i;
  logic       resp_valid_i;
  logic [1:0] start_state_o, end_state_o, probe_len_o;

  logic       rsp_valid = 1'b0;
  logic       rsp_bit = 1'b0;
  logic       inj_valid = 1'b0;
  logic       inj_bit = 1'b0;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // behavioural device
  int  dev_state = 1;
  int  dev_delay = 1;
  bit  dev_silent = 0;
  int  pend = 0;
  int  sym_cnt = 0;
  int  sym_log [2];

  always #10 clk = ~clk;

  assign resp_valid_i = rsp_valid | inj_valid;
  assign resp_bit_i   = inj_valid ? inj_bit : rsp_bit;

  adsi_identifier #(.TIMEOUT_CYC(TMO)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .busy_o        (busy_o),
    .probe_sym_o   (probe_sym_o),
    .probe_valid_o (probe_valid_o),
    .resp_bit_i    (resp_bit_i),
    .resp_valid_i  (resp_valid_i),
    .done_o        (done_o),
    .timeout_o     (timeout_o),
    .start_state_o (start_state_o),
    .end_state_o   (end_state_o),
    .probe_len_o   (probe_len_o)
  );

  // Device model: s1 a/0->s1 b/1->s2; s2 a/1->s2 b/1->s3; s3 a/0->s3 b/0->s1
  initial begin
    forever begin
      @(negedge clk);
      if (pend > 0) begin
        pend = pend - 1;
        if (pend == 0) rsp_valid = 1'b1;
      end else begin
        rsp_valid = 1'b0;
      end
      if (probe_valid_o) begin
        if (sym_cnt < 2) sym_log[sym_cnt] = int'(probe_sym_o);
        sym_cnt = sym_cnt + 1;
        if (probe_sym_o == 1'b0) begin
          rsp_bit = (dev_state == 2);
        end else begin
          rsp_bit = (dev_state != 3);
          dev_state = (dev_state == 3) ? 1 : dev_state + 1;
        end
        if (!dev_silent) pend = dev_delay;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Runs one identification; returns the negedge count from start to done.
  task automatic run_id(input int init, input int dly, input bit silent, output int lat);
    dev_state  = init;
    dev_delay  = dly;
    dev_silent = silent;
    sym_cnt    = 0;
    sym_log[0] = -1;
    sym_log[1] = -1;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(probe_valid_o && probe_sym_o == 1'b0, "R2 first symbol a", int'(probe_sym_o), 0);
    chk(busy_o, "R9 busy after start", int'(busy_o), 1);
    lat = 1;
    while (!done_o && lat < 200) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic expect_ok(input int init, input int dly);
    int lat, exp_first, exp_last, exp_len, exp_lat;
    exp_first = init;
    run_id(init, dly, 1'b0, lat);
    exp_last = dev_state;
    exp_len  = sym_cnt;
    exp_lat  = (exp_len == 1) ? 2 + dly : 3 + 2 * dly;
    chk(exp_len == ((init == 2) ? 1 : 2), "R3/R4 symbols sent", sym_cnt, (init == 2) ? 1 : 2);
    if (init == 2) begin
      chk(start_state_o == 2'd2 && end_state_o == 2'd2 && probe_len_o == 2'd1,
          "R3 verdict state 2", int'(start_state_o), 2);
    end else begin
      chk(sym_log[1] == 1, "R4 second symbol b", sym_log[1], 1);
      chk(int'(start_state_o) == exp_first, "R5 start state", int'(start_state_o), exp_first);
      chk(int'(end_state_o) == exp_last, "R5 end state", int'(end_state_o), exp_last);
      chk(probe_len_o == 2'd2, "R5 length", int'(probe_len_o), 2);
    end
    chk(lat == exp_lat, "R6 completion latency", lat, exp_lat);
    chk(!timeout_o, "R7 no timeout", int'(timeout_o), 0);
    chk(!busy_o, "R9 idle at done", int'(busy_o), 0);
    @(negedge clk);
    chk(!done_o, "R6 done one cycle", int'(done_o), 0);
    repeat (3) @(negedge clk);
    chk(int'(start_state_o) == exp_first && int'(probe_len_o) == exp_len,
        "R6 fields held", int'(start_state_o), exp_first);
  endtask

  task automatic t_reset;
    chk(!busy_o && !probe_valid_o && !done_o && !timeout_o, "R1 control outputs idle",
        int'({busy_o, probe_valid_o, done_o, timeout_o}), 0);
    chk(start_state_o == 0 && end_state_o == 0 && probe_len_o == 0, "R1 fields zero",
        int'({start_state_o, end_state_o, probe_len_o}), 0);
  endtask

  task automatic t_all_states;
    expect_ok(2, 1);
    expect_ok(1, 1);
    expect_ok(3, 1);
    expect_ok(3, 4);
    expect_ok(1, 7);
  endtask

  task automatic t_timeout;
    int lat;
    run_id(3, 1, 1'b1, lat);
    chk(timeout_o && done_o, "R7 timeout flagged", int'(timeout_o), 1);
    chk(lat == 2 + TMO, "R7 timeout latency", lat, 2 + TMO);
    chk(start_state_o == 0 && end_state_o == 0 && probe_len_o == 0, "R7 fields cleared",
        int'(probe_len_o), 0);
    chk(sym_cnt == 1, "R7 no b after silence", sym_cnt, 1);
    repeat (2) @(negedge clk);
    expect_ok(2, TMO);
    chk(!timeout_o, "R7 flag cleared by success", int'(timeout_o), 0);
    // reply one cycle too late
    run_id(1, TMO + 1, 1'b0, lat);
    chk(timeout_o, "R7 reply past limit", int'(timeout_o), 1);
    repeat (4) @(negedge clk);
    expect_ok(3, TMO);
  endtask

  task automatic t_ignore;
    int lat;
    // stray reply while idle
    @(negedge clk);
    inj_bit = 1'b1;
    inj_valid = 1'b1;
    @(negedge clk);
    inj_valid = 1'b0;
    chk(!done_o && !busy_o, "R8 stray reply ignored", int'(done_o), 0);
    chk(start_state_o == 2'd3 && probe_len_o == 2'd2, "R8 fields untouched",
        int'(start_state_o), 3);
    // restart while busy
    dev_state = 1; dev_delay = 6; dev_silent = 0; sym_cnt = 0;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    chk(busy_o, "R9 busy while waiting", int'(busy_o), 1);
    @(negedge clk);
    start_i = 1'b0;
    lat = 0;
    while (!done_o && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    chk(sym_cnt == 2, "R8 restart ignored symbol count", sym_cnt, 2);
    chk(start_state_o == 2'd1 && end_state_o == 2'd2, "R8 verdict after restart",
        int'(start_state_o), 1);
    @(negedge clk);
    chk(!busy_o && !probe_valid_o, "R8 no new probe", int'(probe_valid_o), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_all_states();
    t_timeout();
    t_ignore();
    repeat (3) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule